// File: doc/BRIEF.md
# Chained FIFO Segments with Token-Passed Depth Expansion

This block builds one deep first-in/first-out buffer out of several identical segments. Each segment holds its own storage, write pointer, read pointer and occupancy count. There is no shared address space. Instead, a write token and a read token travel around a ring of segments. Only the segment that holds the write token accepts the shared write strobe. Only the segment that holds the read token presents data on the shared output bus and accepts the shared read strobe.

A segment hands a token on when it writes or reads its last physical location. It does this by raising its expansion-out wire for that cycle. That wire feeds the expansion-in of the next segment in the ring. Write hand-offs and read hand-offs from one sender always alternate. Each receiver therefore keeps a one-bit qualifier that tells it which token the next pulse carries. A first-load strap marks the segment that starts with both tokens after reset.

The top level chains `NUM_SEG` segments (three by default). The output bus shows the oldest word ahead of the read, and is zero while the buffer is empty. The top also forms the composite active-low empty and full flags from the per-segment flags. Reset is asynchronous active-low and is released synchronously inside the top.

Top module: `xchain_fifo`

## Requirements
- R1: While reset is held, and right after it is released, `empty_n` is 0, `full_n` is 1, every bit of `seg_empty_n` is 0, every bit of `seg_full_n` is 1, `rd_data` is 0 and `seg_xo` is 0; reset also discards any stored words.
- R2: Words leave in the order they were accepted, including across segment boundaries and across wrap-around of the ring; `rd_data` shows the oldest stored word while the buffer is non-empty, and a read accepted at a clock edge removes that word.
- R3: Total capacity is `NUM_SEG*SEG_DEPTH` words; `full_n` goes low exactly when that many words are stored, and a write strobe while full changes neither the stored contents nor the flags.
- R4: A read strobe while empty has no effect, and `rd_data` is all zeros while the buffer is empty.
- R5: `seg_xo[k]` is high during a cycle in which segment k accepts a write into its last location (index `SEG_DEPTH-1`) or accepts a read from its last location, and is low otherwise.
- R6: After reset, segment 0 takes the first `SEG_DEPTH` writes and segment k takes the next run after segment k-1. `seg_empty_n[k]` is low exactly when segment k holds no words, and `seg_full_n[k]` is low exactly when it holds `SEG_DEPTH` words.
- R7: `empty_n` is low exactly when all bits of `seg_empty_n` are low, and `full_n` is low exactly when all bits of `seg_full_n` are low.
- R8: At every cycle out of reset, exactly one segment holds the write token and exactly one holds the read token; a segment gains a token only in the cycle after its expansion-in was high.
- R9: Read and write strobes in the same cycle both take effect; when empty only the write takes effect, and when full only the read does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| rd_data | output | WIDTH | Oldest stored word, zero while empty |
| empty_n | output | 1 | Composite empty flag, active low |
| full_n | output | 1 | Composite full flag, active low |
| seg_empty_n | output | NUM_SEG | Per-segment empty flags, active low |
| seg_full_n | output | NUM_SEG | Per-segment full flags, active low |
| seg_xo | output | NUM_SEG | Per-segment expansion-out hand-off pulses |

## Verification
The token and occupancy properties assume that strobes are sampled only at rising edges and that stimulus keeps them stable between edges. The stimulus therefore drives every input on the falling edge. The hand-off properties rely on the fact that a segment can never write and read its last location in the same cycle. The strobes alone cannot break this, so the bench issues arbitrary combinations of reads and writes, including overflow and underflow attempts. The bench only waits on reset release for the two-stage synchronizer, and it drives no strobe while reset is active.

// File: rtl/xchain_pkg.sv
package xchain_pkg;
  // Token state a segment reports to the ring level.
  typedef struct packed {
    logic wtok;
    logic rtok;
  } tok_state_t;

  function automatic int unsigned ring_prev(int unsigned idx, int unsigned n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction
endpackage

// File: rtl/xchain_mem.sv
module xchain_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/xchain_ptr.sv
module xchain_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic          at_last
);
  logic [AW-1:0] ptr_q, ptr_d;

  assign at_last = (ptr_q == LAST);

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      ptr_d = at_last ? '0 : ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/xchain_token.sv
module xchain_token
  import xchain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       first_load_n,
  input  logic       xi,
  input  logic       give_w,
  input  logic       give_r,
  output tok_state_t tok
);
  logic       wtok_q, wtok_d;
  logic       rtok_q, rtok_d;
  logic       expect_w_q, expect_w_d;
  logic       take_w, take_r;

  // Pulses from one sender alternate: write hand-off, then read hand-off.
  assign take_w = xi & expect_w_q;
  assign take_r = xi & ~expect_w_q;

  always_comb begin
    expect_w_d = xi ? ~expect_w_q : expect_w_q;
    wtok_d     = wtok_q;
    rtok_d     = rtok_q;
    if (give_w)      wtok_d = 1'b0;
    else if (take_w) wtok_d = 1'b1;
    if (give_r)      rtok_d = 1'b0;
    else if (take_r) rtok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtok_q     <= ~first_load_n;
      rtok_q     <= ~first_load_n;
      expect_w_q <= 1'b1;
    end else begin
      wtok_q     <= wtok_d;
      rtok_q     <= rtok_d;
      expect_w_q <= expect_w_d;
    end
  end

  assign tok.wtok = wtok_q;
  assign tok.rtok = rtok_q;

  // R8
  wtok_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wtok_q) |-> $past(xi));
  // R8
  rtok_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtok_q) |-> $past(xi));
endmodule

// File: rtl/xchain_segment.sv
module xchain_segment
  import xchain_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  logic             xi,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n,
  output logic             full_n,
  output logic             xo,
  output tok_state_t       tok
);
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [AW-1:0]    wptr, rptr;
  logic [WIDTH-1:0] head;
  logic             seg_full, seg_empty;
  logic             wr_fire, rd_fire;
  logic             w_last, r_last;
  logic             give_w, give_r;

  assign seg_full  = (cnt_q == CW'(DEPTH));
  assign seg_empty = (cnt_q == '0);
  assign wr_fire   = wr_en & tok.wtok & ~seg_full;
  assign rd_fire   = rd_en & tok.rtok & ~seg_empty;
  assign give_w    = wr_fire & w_last;
  assign give_r    = rd_fire & r_last;

  xchain_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_fire), .ptr(wptr), .at_last(w_last)
  );

  xchain_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_fire), .ptr(rptr), .at_last(r_last)
  );

  xchain_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(head)
  );

  xchain_token u_tok (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .xi(xi),
    .give_w(give_w), .give_r(give_r), .tok(tok)
  );

  always_comb begin
    unique case ({wr_fire, rd_fire})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_fire ^ rd_fire) begin
      cnt_q <= cnt_d;
    end
  end

  assign xo      = give_w | give_r;
  assign rd_data = (tok.rtok & ~seg_empty) ? head : '0;
  assign empty_n = ~seg_empty;
  assign full_n  = ~seg_full;

  // R5
  single_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(give_w && give_r));
  // R8
  wtok_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give_w |=> !tok.wtok);
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/xchain_fifo.sv
module xchain_fifo
  import xchain_pkg::*;
#(
  parameter int WIDTH     = 9,
  parameter int SEG_DEPTH = 8,
  parameter int NUM_SEG   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               rd_en,
  output logic [WIDTH-1:0]   rd_data,
  output logic               empty_n,
  output logic               full_n,
  output logic [NUM_SEG-1:0] seg_empty_n,
  output logic [NUM_SEG-1:0] seg_full_n,
  output logic [NUM_SEG-1:0] seg_xo
);
  logic [1:0]         rst_sync_q;
  logic               srst_n;
  logic [WIDTH-1:0]   seg_data [NUM_SEG];
  tok_state_t         seg_tok  [NUM_SEG];
  logic [NUM_SEG-1:0] wtok_v, rtok_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    xchain_segment #(.WIDTH(WIDTH), .DEPTH(SEG_DEPTH)) u_seg (
      .clk          (clk),
      .rst_n        (srst_n),
      .first_load_n (g != 0),
      .xi           (seg_xo[ring_prev(g, NUM_SEG)]),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_en        (rd_en),
      .rd_data      (seg_data[g]),
      .empty_n      (seg_empty_n[g]),
      .full_n       (seg_full_n[g]),
      .xo           (seg_xo[g]),
      .tok          (seg_tok[g])
    );
    assign wtok_v[g] = seg_tok[g].wtok;
    assign rtok_v[g] = seg_tok[g].rtok;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      rd_data = rd_data | seg_data[i];
    end
  end

  assign empty_n = |seg_empty_n;
  assign full_n  = |seg_full_n;

  // R8
  wtok_unique_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(wtok_v) == 1);
  // R8
  rtok_unique_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(rtok_v) == 1);
  // R3
  full_holds_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!full_n && wr_en && !rd_en) |=> (!full_n && $stable(rd_data)));
  // R4
  empty_holds_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!empty_n && rd_en && !wr_en) |=> !empty_n);
endmodule

// File: tb/xchain_fifo_bench.sv
module xchain_fifo_bench;
  localparam int W   = 9;
  localparam int D   = 8;
  localparam int NS  = 3;
  localparam int CAP = D * NS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  rd_data;
  logic          empty_n, full_n;
  logic [NS-1:0] seg_empty_n, seg_full_n, seg_xo;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] q[$];
  int  occ, wpos, rpos;
  int  scnt [NS];
  bit  w_ok, r_ok, mon_on;
  logic [W-1:0] lfsr;

  always #10 clk = ~clk;

  xchain_fifo #(.WIDTH(W), .SEG_DEPTH(D), .NUM_SEG(NS)) u_xchain_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
    .seg_empty_n(seg_empty_n), .seg_full_n(seg_full_n), .seg_xo(seg_xo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares outputs with the scoreboard, then retires the cycle.
  always begin
    @(negedge clk);
    #5;
    if (mon_on) begin
      logic [NS-1:0] exp_xo;
      logic [W-1:0]  exp_head;
      exp_xo = '0;
      if (w_ok && (wpos % D) == D - 1) exp_xo[wpos / D] = 1'b1;
      if (r_ok && (rpos % D) == D - 1) exp_xo[rpos / D] = 1'b1;
      exp_head = (occ != 0) ? q[0] : '0;
      // R7 composite flags against the modelled occupancy
      check(empty_n === (occ != 0), "R7 empty_n", empty_n, occ != 0);
      check(full_n === (occ != CAP), "R3 full_n", full_n, occ != CAP);
      for (int s = 0; s < NS; s++) begin
        // R6 per-segment flags
        check(seg_empty_n[s] === (scnt[s] != 0), "R6 seg_empty_n", seg_empty_n[s], scnt[s] != 0);
        check(seg_full_n[s] === (scnt[s] != D), "R6 seg_full_n", seg_full_n[s], scnt[s] != D);
      end
      if (occ != 0) check(rd_data === exp_head, "R2 head order", rd_data, exp_head);
      else          check(rd_data === '0, "R4 empty bus", rd_data, 0);
      // R5 hand-off pulses
      check(seg_xo === exp_xo, "R5 seg_xo", seg_xo, exp_xo);
      if (r_ok) begin
        void'(q.pop_front());
        occ--;
        scnt[rpos / D]--;
        rpos = (rpos + 1) % CAP;
      end
      if (w_ok) begin
        occ++;
        scnt[wpos / D]++;
        wpos = (wpos + 1) % CAP;
      end
    end
  end

  // Driver: applies one cycle of strobes and pushes accepted words.
  task automatic drive(input bit w, input bit r, input logic [W-1:0] d);
    @(negedge clk);
    wr_en   = w;
    rd_en   = r;
    wr_data = d;
    // R9 acceptance rule: write needs space, read needs data
    w_ok = w && (q.size() < CAP);
    r_ok = r && (q.size() > 0);
    if (w_ok) q.push_back(d);
  endtask

  task automatic next_lfsr();
    lfsr = {lfsr[W-2:0], lfsr[W-1] ^ lfsr[4]};
  endtask

  task automatic check_reset_state(input string tag);
    check(empty_n === 1'b0, tag, empty_n, 0);
    check(full_n === 1'b1, tag, full_n, 1);
    check(seg_empty_n === '0, tag, seg_empty_n, 0);
    check(seg_full_n === '1, tag, seg_full_n, {NS{1'b1}});
    check(rd_data === '0, tag, rd_data, 0);
    check(seg_xo === '0, tag, seg_xo, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    mon_on = 1'b0;
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    w_ok   = 1'b0;
    r_ok   = 1'b0;
    q.delete();
    occ = 0; wpos = 0; rpos = 0;
    for (int s = 0; s < NS; s++) scnt[s] = 0;
    repeat (3) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R1 after release");
    mon_on = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    w_ok = 1'b0; r_ok = 1'b0; mon_on = 1'b0; lfsr = 9'h1A5;
    do_reset();

    // R6 R3: fill to capacity, then overflow attempts are ignored
    for (int i = 0; i < CAP + 3; i++) drive(1'b1, 1'b0, W'(i * 7 + 1));
    drive(1'b0, 1'b0, '0);
    // R3 capacity reached after exactly CAP writes
    check(occ == CAP && full_n === 1'b0, "R3 capacity", occ, CAP);

    // R9 at full: read accepted, write refused
    drive(1'b1, 1'b1, 9'h1FF);
    drive(1'b0, 1'b0, '0);

    // R2 R4: drain across all boundaries, then underflow attempts
    for (int i = 0; i < CAP + 3; i++) drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
    check(occ == 0 && empty_n === 1'b0, "R4 drained", occ, 0);

    // R9 at empty: write accepted, read refused
    drive(1'b1, 1'b1, 9'h0AB);
    drive(1'b0, 1'b0, '0);
    check(occ == 1, "R9 empty simultaneous", occ, 1);

    // R2 R8: mixed traffic with many ring wrap-arounds
    for (int i = 0; i < 1500; i++) begin
      bit w, r;
      next_lfsr();
      w = lfsr[0] | (lfsr[3] & lfsr[5]);
      r = lfsr[1] | (lfsr[2] & ~lfsr[7]);
      if (i % 300 > 220) r = lfsr[1] & lfsr[2];
      drive(w, r, lfsr);
    end
    drive(1'b0, 1'b0, '0);

    // R1: reset with words stored discards them
    for (int i = 0; i < 11; i++) drive(1'b1, 1'b0, W'(i + 40));
    drive(1'b0, 1'b0, '0);
    do_reset();

    // R2 R6: order from a clean start after the second reset
    for (int i = 0; i < D + 2; i++) drive(1'b1, 1'b0, W'(200 + i));
    for (int i = 0; i < D + 4; i++) drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule